// File: doc/BRIEF.md
# Integer add / reverse-subtract unit with carry keep

This execution unit performs 32-bit addition and reverse subtraction for a small RISC pipeline. It owns the machine status register (MSR). The MSR holds a carry flag and a mirrored copy of that flag, plus one bit that software can never change. Each operation comes with two operands, a two-bit slice of the decoded opcode, an operation select and a destination register index. The unit returns a registered register-file write (enable, index, data) and the current MSR contents.

Reverse subtraction forms `b + ~a + cin`. The opcode slice picks the carry-in and decides whether the carry flag is updated. A separate software path writes the MSR directly. That path can change every bit except the protected version-present bit.

Top module: `addsub_carry_unit`

## Requirements
- R1: With `sub_i`=0 the result is `a_i + b_i + cin` modulo 2^32. `cin` is 0 when `opcode_i[1]` (carry-use) is 0, and is the stored carry (MSR bit 31) when it is 1.
- R2: With `sub_i`=1 the result is `b_i + ~a_i + cin` modulo 2^32. `cin` is 1 when `opcode_i[1]` is 0, and is the stored carry (MSR bit 31) when it is 1.
- R3: When `opcode_i[2]` (keep) is 0, the carry-out of the 33-bit sum of the three addends is written to MSR bit 31 and to its mirror bit 2 together. All other MSR bits are left unchanged.
- R4: When `opcode_i[2]` is 1, the operation leaves the MSR unchanged. The carry-use choice still applies to the result.
- R5: When `dest_i` is 0, no register write is issued (`rf_we_o` stays 0). A non-keep operation still updates the carry bits.
- R6: An operation with keep set and `dest_i`=0 changes neither the MSR nor the register-write outputs.
- R7: A software write (`msr_we_i`) loads `msr_wdata_i` into every MSR bit except bit 10, which keeps its previous value.
- R8: The register write and the MSR update of an operation (`valid_i`=1) appear on the clock edge that samples it. `rf_we_o` is 0 after any edge at which `valid_i` was 0.
- R9: After reset the MSR equals 32'h0000_0400 (only bit 10 set) and `rf_we_o` is 0.
- R10: If a software write and a non-keep operation fall on the same edge, bits 31 and 2 take the operation's carry-out and the other bits follow R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| sub_i | input | 1 | 0: add, 1: reverse subtract |
| opcode_i | input | 2 | Opcode bits [2:1]: bit 2 keep, bit 1 carry-use |
| dest_i | input | 5 | Destination register index |
| a_i | input | 32 | Operand a |
| b_i | input | 32 | Operand b |
| msr_we_i | input | 1 | Software MSR write strobe |
| msr_wdata_i | input | 32 | Software MSR write data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| msr_o | output | 32 | Current MSR contents |

## Verification
Every result in this block lands exactly one clock edge after its stimulus. This holds for the register-write triple, the carry and mirror bits, and the software MSR write. The bench drives inputs on the falling edge and checks at the next falling edge, which is half a cycle after the capturing edge. It then withdraws the strobes, so each check sees only the effect of its own operation. The stored carry that a carry-use operation consumes is set beforehand through the software path. This keeps the expected carry-in known to the bench's own MSR model.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int XLEN       = 32;
  localparam int REG_IDX_W  = 5;
  localparam int CARRY_BIT  = 31;
  localparam int MIRROR_BIT = 2;
  localparam int PROT_BIT   = 10;
  localparam logic [XLEN-1:0] MSR_RESET = 32'h0000_0400;
  localparam int KEEP_POS   = 2;
  localparam int USEC_POS   = 1;

  typedef enum logic {OP_ADD = 1'b0, OP_RSUB = 1'b1} op_e;
endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int W = 32
) (
  input  logic         sub_i,
  input  logic         use_c_i,
  input  logic         carry_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] opa;
  logic         cin;
  logic [W:0]   full;

  always_comb begin
    opa  = sub_i ? ~a_i : a_i;
    // default carry-in: 0 for add, 1 for reverse subtract
    cin  = use_c_i ? carry_i : sub_i;
    full = {1'b0, opa} + {1'b0, b_i} + {{W{1'b0}}, cin};
  end

  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/msr_reg.sv
module msr_reg #(
  parameter int W          = 32,
  parameter int CARRY_BIT  = 31,
  parameter int MIRROR_BIT = 2,
  parameter int PROT_BIT   = 10,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_we_i,
  input  logic [W-1:0] sw_data_i,
  input  logic         c_we_i,
  input  logic         c_val_i,
  output logic [W-1:0] msr_o
);
  localparam logic [W-1:0] PROT_MASK  = W'(1) << PROT_BIT;
  localparam logic [W-1:0] CARRY_MASK = (W'(1) << CARRY_BIT) | (W'(1) << MIRROR_BIT);

  logic [W-1:0] msr_q, base, nxt;

  always_comb begin
    base = sw_we_i ? ((sw_data_i & ~PROT_MASK) | (msr_q & PROT_MASK)) : msr_q;
    nxt  = base;
    if (c_we_i) nxt = (base & ~CARRY_MASK) | ({W{c_val_i}} & CARRY_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) msr_q <= RESET_VAL;
    else         msr_q <= nxt;
  end

  assign msr_o = msr_q;
endmodule

// File: rtl/wb_reg.sv
module wb_reg #(
  parameter int W     = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [W-1:0]     data_i,
  output logic             we_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [W-1:0]     data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      idx_o  <= '0;
      data_o <= '0;
    end else begin
      we_o <= we_i;
      if (we_i) begin
        idx_o  <= idx_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/addsub_carry_unit.sv
module addsub_carry_unit
  import addsub_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 sub_i,
  input  logic [2:1]           opcode_i,
  input  logic [REG_IDX_W-1:0] dest_i,
  input  logic [XLEN-1:0]      a_i,
  input  logic [XLEN-1:0]      b_i,
  input  logic                 msr_we_i,
  input  logic [XLEN-1:0]      msr_wdata_i,
  output logic                 rf_we_o,
  output logic [REG_IDX_W-1:0] rf_waddr_o,
  output logic [XLEN-1:0]      rf_wdata_o,
  output logic [XLEN-1:0]      msr_o
);
  logic          keep, use_c, cout, rf_we, c_we;
  logic [XLEN-1:0] sum;
  op_e           op;

  assign keep  = opcode_i[KEEP_POS];
  assign use_c = opcode_i[USEC_POS];
  assign op    = op_e'(sub_i);
  assign rf_we = valid_i && (dest_i != '0);
  assign c_we  = valid_i && !keep;

  addsub_core #(.W(XLEN)) u_core (
    .sub_i   (op == OP_RSUB),
    .use_c_i (use_c),
    .carry_i (msr_o[CARRY_BIT]),
    .a_i     (a_i),
    .b_i     (b_i),
    .sum_o   (sum),
    .cout_o  (cout)
  );

  msr_reg #(
    .W(XLEN), .CARRY_BIT(CARRY_BIT), .MIRROR_BIT(MIRROR_BIT),
    .PROT_BIT(PROT_BIT), .RESET_VAL(MSR_RESET)
  ) u_msr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_we_i   (msr_we_i),
    .sw_data_i (msr_wdata_i),
    .c_we_i    (c_we),
    .c_val_i   (cout),
    .msr_o     (msr_o)
  );

  wb_reg #(.W(XLEN), .IDX_W(REG_IDX_W)) u_wb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (rf_we),
    .idx_i  (dest_i),
    .data_i (sum),
    .we_o   (rf_we_o),
    .idx_o  (rf_waddr_o),
    .data_o (rf_wdata_o)
  );
endmodule

// File: rtl/addsub_chk.sv
module addsub_chk
  import addsub_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [2:1]           opcode_i,
  input logic [REG_IDX_W-1:0] dest_i,
  input logic                 msr_we_i,
  input logic                 rf_we_o,
  input logic [REG_IDX_W-1:0] rf_waddr_o,
  input logic [XLEN-1:0]      msr_o
);
  assert_no_r0_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_waddr_o != '0));

  assert_write_follows_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dest_i != '0) |=> (rf_we_o && rf_waddr_o == $past(dest_i)));

  assert_idle_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !rf_we_o);

  assert_keep_holds_msr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[KEEP_POS] && !msr_we_i) |=> $stable(msr_o));

  assert_mirror_matches_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !opcode_i[KEEP_POS]) |=> (msr_o[CARRY_BIT] == msr_o[MIRROR_BIT]));

  assert_prot_bit_fixed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(msr_o[PROT_BIT]));

  assert_no_change_without_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msr_we_i && !(valid_i && !opcode_i[KEEP_POS])) |=> $stable(msr_o));
endmodule

bind addsub_carry_unit addsub_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .opcode_i   (opcode_i),
  .dest_i     (dest_i),
  .msr_we_i   (msr_we_i),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .msr_o      (msr_o)
);

// File: tb/tb_addsub_carry_unit.sv
module tb_addsub_carry_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        valid_i = 0, sub_i = 0, msr_we_i = 0;
  logic [2:1]  opcode_i = '0;
  logic [4:0]  dest_i = '0;
  logic [31:0] a_i = '0, b_i = '0, msr_wdata_i = '0;
  logic        rf_we_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o, msr_o;

  int checks = 0, errors = 0;
  logic [31:0] m_msr;  // bench-side MSR model

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  addsub_carry_unit dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sw_apply(input logic [31:0] old, input logic [31:0] d);
    return (d & ~32'h400) | (old & 32'h400);
  endfunction

  function automatic logic [31:0] set_c(input logic [31:0] m, input logic c);
    logic [31:0] r = m;
    r[31] = c;
    r[2]  = c;
    return r;
  endfunction

  task automatic sw_write(input logic [31:0] d, input string req);
    @(negedge clk_i);
    msr_we_i = 1; msr_wdata_i = d;
    @(negedge clk_i);
    msr_we_i = 0;
    m_msr = sw_apply(m_msr, d);
    chk(msr_o == m_msr, req, msr_o, m_msr);
  endtask

  // drive one op (optionally with a concurrent software write) and check next edge
  task automatic run_op(input bit sub, input bit keep, input bit usec, input logic [4:0] dest,
                        input logic [31:0] a, input logic [31:0] b,
                        input bit sw, input logic [31:0] swd, input string req);
    logic [32:0] full;
    logic cin;
    logic [31:0] exp_msr;
    @(negedge clk_i);
    valid_i = 1; sub_i = sub; opcode_i = {keep, usec}; dest_i = dest; a_i = a; b_i = b;
    msr_we_i = sw; msr_wdata_i = swd;
    cin  = usec ? m_msr[31] : sub;
    full = {1'b0, (sub ? ~a : a)} + {1'b0, b} + {32'd0, cin};
    exp_msr = sw ? sw_apply(m_msr, swd) : m_msr;
    if (!keep) exp_msr = set_c(exp_msr, full[32]);
    @(negedge clk_i);
    valid_i = 0; msr_we_i = 0;
    chk(rf_we_o == (dest != 0), {req, " we"}, {31'd0, rf_we_o}, {31'd0, dest != 0});
    if (dest != 0) begin
      chk(rf_waddr_o == dest, {req, " idx"}, {27'd0, rf_waddr_o}, {27'd0, dest});
      chk(rf_wdata_o == full[31:0], {req, " data"}, rf_wdata_o, full[31:0]);
    end
    chk(msr_o == exp_msr, {req, " msr"}, msr_o, exp_msr);
    m_msr = exp_msr;
  endtask

  task automatic t_reset;
    chk(msr_o == 32'h400, "R9 msr", msr_o, 32'h400);
    chk(rf_we_o == 1'b0, "R9 we", {31'd0, rf_we_o}, 32'd0);
  endtask

  task automatic t_add;
    sw_write(32'h0, "R7 clear");
    run_op(0, 0, 0, 5'd3, 32'h0000_0005, 32'h0000_0007, 0, 0, "R1 add");
    run_op(0, 0, 0, 5'd4, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, "R3 add carry out");
    run_op(0, 0, 1, 5'd5, 32'h0000_0010, 32'h0000_0020, 0, 0, "R1 add use carry");
    chk(rf_wdata_o == 32'h31, "R1 carry added", rf_wdata_o, 32'h31);
  endtask

  task automatic t_sub;
    run_op(1, 0, 0, 5'd6, 32'h0000_0003, 32'h0000_000A, 0, 0, "R2 rsub");
    chk(rf_wdata_o == 32'h7, "R2 b-a", rf_wdata_o, 32'h7);
    run_op(1, 0, 0, 5'd7, 32'h0000_000A, 32'h0000_0003, 0, 0, "R2 rsub borrow");
    sw_write(32'h0, "R7 clear c");
    run_op(1, 0, 1, 5'd8, 32'h0000_0003, 32'h0000_000A, 0, 0, "R2 rsub carry 0");
    chk(rf_wdata_o == 32'h6, "R2 cin zero", rf_wdata_o, 32'h6);
  endtask

  task automatic t_keep;
    sw_write(32'h8000_0004, "R7 set c");
    run_op(0, 1, 1, 5'd9, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, "R4 keep add");
    chk(rf_wdata_o == 32'h1, "R4 keep uses carry", rf_wdata_o, 32'h1);
    sw_write(32'h0000_0000, "R7 clear");
    run_op(1, 1, 0, 5'd10, 32'h0000_0000, 32'h0000_0000, 0, 0, "R4 keep rsub");
  endtask

  task automatic t_dest0;
    sw_write(32'h0, "R7 clear");
    run_op(0, 0, 0, 5'd0, 32'hFFFF_FFFF, 32'h0000_0002, 0, 0, "R5 dest0 carry");
    chk(msr_o[31] && msr_o[2], "R5 carry set", msr_o, 32'h8000_0004);
    run_op(0, 1, 0, 5'd0, 32'h0000_0000, 32'h0000_0000, 0, 0, "R6 keep dest0");
  endtask

  task automatic t_sw;
    sw_write(32'h0000_0000, "R7 cannot clear bit10");
    chk(msr_o[10] == 1'b1, "R7 bit10 kept", msr_o, 32'h400);
    sw_write(32'h7FFF_FBFB, "R7 write pattern");
    run_op(0, 0, 0, 5'd11, 32'hFFFF_FFFF, 32'h1, 1, 32'h0000_00F0, "R10 concurrent");
    @(negedge clk_i);
    chk(rf_we_o == 1'b0, "R8 idle no write", {31'd0, rf_we_o}, 32'd0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 200; i++) begin
      run_op(1'($urandom), 1'(i % 4 / 2), 1'(i % 2), 5'($urandom),
             $urandom, $urandom, 0, 0, "R1 R2 R3 random");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(7));
    m_msr = 32'h400;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_add();
    t_sub();
    t_keep();
    t_dest0();
    t_sw();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule